// File: doc/BRIEF.md
# Successive-Approximation Arithmetic Sequencer

This block is the digital control and result register of a charge-balancing multiplier/divider. The capacitor arrays, amplifiers and comparator sit outside it. A request carries two sign-magnitude operands: x, with XW magnitude bits, and y, with YW magnitude bits. It also carries a mode flag that picks the product x·y or the quotient x/y. Both magnitudes are binary fractions, with the most significant bit weighing one half. The block steps through three phases. The first is one setup cycle, in which the arrays are loaded. The second is one discharge slot. The third is a run of ZW = XW+YW bit trials. Each trial tests one result bit, starting from the most significant. The external comparator decides whether that bit stays set.

At the end of the run the block sits in its output state. It holds the ZW-bit result, the result sign and the array codes that present the result to the output converter. It stays there until a new request arrives. Requests use a valid/ready handshake. `req_ready` is high only in the output state, so a request raised during a run waits and is not taken. The requester keeps `req_valid` and the operand pins steady until the cycle in which both valid and ready are high. Results are not back-pressured: they are held on plain pins, and `done` marks their arrival.

Top module: `sar_arith_seq`

## Requirements
- R1: After reset the block is in the output state, with `req_ready`=1, `z`=0, `err`=0, `done`=0 and no phase strobe high. In that state `z` holds its value while no request is taken.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. One `ph_setup` cycle follows, then one `ph_dis` cycle, then ZW `ph_trial` cycles. `done` is high in the cycle after edge number ZW+2 counted from the accepting edge.
- R3: In trial k (k = 1..ZW), bit ZW-k is under test. `trial_mask` has only that bit set, and {`arr_hi`,`arr_lo`} shows the bits decided so far with that bit forced to 1. At the edge that ends the trial the bit takes the value of `cmp_pos`, and bits decided earlier do not change.
- R4: With `req_div`=0, `z` equals x_mag·y_mag. This is floor(x·y·2^ZW) for the fractional operands.
- R5: With `req_div`=1 and y_mag MSB = 1, `z` equals floor(x_mag·2^(2·YW−1)/y_mag). That is the ratio x/y with one integer bit, so the ratio weight of `z` bit ZW-1 is 1.
- R6: `z_neg` becomes `x_neg` XOR `y_neg` at the accepting edge and holds until the next taken request.
- R7: A division request whose y_mag MSB is 0 is refused. `err` becomes 1 and no setup cycle starts. `z`, `z_neg` and the operand codes keep their values, and `done` stays 0. The next taken valid request clears `err` to 0.
- R8: While `req_ready`=0, `req_valid` and the operand pins have no effect. A run completes with the operands captured at its accepting edge.
- R9: `done` is a single-cycle pulse on entry to the output state.
- R10: `arr_hi` is the upper XW bits and `arr_lo` the lower YW bits of the trial word. In the output state the trial word equals `z`. `op_x_code`, `op_y_code` and `op_div` show the captured operands and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | High in the output state; a request is taken when valid and ready are both high |
| req_div | input | 1 | 0: multiply, 1: divide |
| x_mag | input | XW | Magnitude of x (multiplicand or dividend) |
| x_neg | input | 1 | Sign of x, 1 = negative |
| y_mag | input | YW | Magnitude of y (multiplier or divisor) |
| y_neg | input | 1 | Sign of y, 1 = negative |
| cmp_pos | input | 1 | Comparator: 1 when the residual difference is positive |
| ph_setup | output | 1 | Setup (array load) cycle |
| ph_dis | output | 1 | Discharge slot, no trial |
| ph_trial | output | 1 | Bit-trial cycle |
| trial_mask | output | ZW | One-hot position of the bit under test |
| arr_hi | output | XW | Upper part of the trial word, for the high array |
| arr_lo | output | YW | Lower part of the trial word, for the low array |
| op_x_code | output | XW | Captured x magnitude |
| op_y_code | output | YW | Captured y magnitude |
| op_div | output | 1 | Captured mode |
| z | output | ZW | Result register |
| z_neg | output | 1 | Result sign, selects an inverting output |
| done | output | 1 | One-cycle pulse when a result becomes available |
| err | output | 1 | Last taken request was an unnormalized division |

## Verification
The bound checker watches the phase order on every cycle: setup is followed by discharge, discharge by a trial, and the last trial by `done`. It also checks that the trial mask is at most one-hot, that decided bits never change during a trial, that `done` never lasts two cycles, that a request is never taken mid-run, and that `z` and `z_neg` hold while idle. The arithmetic values themselves can only be shown by the bench scenarios. These are the product and quotient against a comparator model, the exact latency, the refusal of an unnormalized divisor, forced comparator patterns, and operand changes during a run.

// File: rtl/sar_arith_pkg.sv
package sar_arith_pkg;
  typedef enum logic [1:0] {
    ST_OUT   = 2'd0,
    ST_SETUP = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_ctrl.sv
// Phase sequencer: output state, one setup cycle, discharge slot, ZW trials.
module sar_ctrl #(
  parameter int ZW = 8,
  localparam int CW = $clog2(ZW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ready,
  output logic          ph_setup,
  output logic          ph_dis,
  output logic          ph_trial,
  output logic [CW-1:0] slot,
  output logic          done
);
  import sar_arith_pkg::*;

  seq_state_e state_q;
  logic       last_slot;

  assign last_slot = (slot == CW'(ZW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OUT;
      slot    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_OUT: begin
          if (start) begin
            state_q <= ST_SETUP;
            slot    <= '0;
          end
        end
        ST_SETUP: begin
          state_q <= ST_CONV;
          slot    <= '0;
        end
        ST_CONV: begin
          if (last_slot) begin
            state_q <= ST_OUT;
            slot    <= '0;
            done    <= 1'b1;
          end else begin
            slot <= slot + CW'(1);
          end
        end
        default: state_q <= ST_OUT;
      endcase
    end
  end

  assign ready    = (state_q == ST_OUT);
  assign ph_setup = (state_q == ST_SETUP);
  assign ph_dis   = (state_q == ST_CONV) && (slot == '0);
  assign ph_trial = (state_q == ST_CONV) && (slot != '0);
endmodule

// File: rtl/sar_operand_latch.sv
// Operand capture, sign and divisor normalization check.
module sar_operand_latch #(
  parameter int XW = 4,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          div_in,
  input  logic [XW-1:0] x_in,
  input  logic          x_neg_in,
  input  logic [YW-1:0] y_in,
  input  logic          y_neg_in,
  output logic          start,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q,
  output logic          div_q,
  output logic          neg_q,
  output logic          err_q
);
  logic bad;

  assign bad   = div_in && !y_in[YW-1];
  assign start = fire && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      div_q <= 1'b0;
      neg_q <= 1'b0;
      err_q <= 1'b0;
    end else if (fire) begin
      err_q <= bad;
      if (!bad) begin
        x_q   <= x_in;
        y_q   <= y_in;
        div_q <= div_in;
        neg_q <= x_neg_in ^ y_neg_in;
      end
    end
  end
endmodule

// File: rtl/sar_result_reg.sv
// Successive-approximation result register with one-hot trial mask.
module sar_result_reg #(
  parameter int ZW = 8,
  localparam int CW = $clog2(ZW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          trial_en,
  input  logic [CW-1:0] slot,
  input  logic          cmp_pos,
  output logic [ZW-1:0] z_q,
  output logic [ZW-1:0] trial_mask,
  output logic [ZW-1:0] trial_word
);
  // slot k (1..ZW) tests bit ZW-k, MSB first
  for (genvar i = 0; i < ZW; i++) begin : g_mask
    assign trial_mask[i] = trial_en && (slot == CW'(ZW - i));
  end

  assign trial_word = z_q | trial_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= '0;
    end else if (clear) begin
      z_q <= '0;
    end else if (trial_en) begin
      z_q <= (z_q & ~trial_mask) | (cmp_pos ? trial_mask : '0);
    end
  end
endmodule

// File: rtl/sar_arith_seq.sv
// Top: sequencer for a charge-balancing multiplier/divider.
module sar_arith_seq #(
  parameter int XW = 4,
  parameter int YW = 4,
  localparam int ZW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_div,
  input  logic [XW-1:0] x_mag,
  input  logic          x_neg,
  input  logic [YW-1:0] y_mag,
  input  logic          y_neg,
  input  logic          cmp_pos,
  output logic          ph_setup,
  output logic          ph_dis,
  output logic          ph_trial,
  output logic [ZW-1:0] trial_mask,
  output logic [XW-1:0] arr_hi,
  output logic [YW-1:0] arr_lo,
  output logic [XW-1:0] op_x_code,
  output logic [YW-1:0] op_y_code,
  output logic          op_div,
  output logic [ZW-1:0] z,
  output logic          z_neg,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(ZW + 1);

  logic          fire;
  logic          start;
  logic [CW-1:0] slot;
  logic [ZW-1:0] trial_word;

  assign fire = req_valid && req_ready;

  sar_operand_latch #(.XW(XW), .YW(YW)) u_ops (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .div_in   (req_div),
    .x_in     (x_mag),
    .x_neg_in (x_neg),
    .y_in     (y_mag),
    .y_neg_in (y_neg),
    .start    (start),
    .x_q      (op_x_code),
    .y_q      (op_y_code),
    .div_q    (op_div),
    .neg_q    (z_neg),
    .err_q    (err)
  );

  sar_ctrl #(.ZW(ZW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (req_ready),
    .ph_setup (ph_setup),
    .ph_dis   (ph_dis),
    .ph_trial (ph_trial),
    .slot     (slot),
    .done     (done)
  );

  sar_result_reg #(.ZW(ZW)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .trial_en   (ph_trial),
    .slot       (slot),
    .cmp_pos    (cmp_pos),
    .z_q        (z),
    .trial_mask (trial_mask),
    .trial_word (trial_word)
  );

  assign arr_hi = trial_word[ZW-1 -: XW];
  assign arr_lo = trial_word[YW-1:0];
endmodule

// File: rtl/sar_arith_seq_chk.sv
// Cycle-level properties of the sequencer, bound to the top.
module sar_arith_seq_chk #(
  parameter int XW = 4,
  parameter int YW = 4,
  localparam int ZW = XW + YW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_div,
  input logic [YW-1:0] y_mag,
  input logic          ph_setup,
  input logic          ph_dis,
  input logic          ph_trial,
  input logic [ZW-1:0] trial_mask,
  input logic [ZW-1:0] z,
  input logic          z_neg,
  input logic          done,
  input logic          err
);
  // R2: setup lasts one cycle and leads into the discharge slot
  a_r2_setup_to_dis: assert property (@(posedge clk) disable iff (!rst_n)
    ph_setup |=> ph_dis);
  // R2: discharge slot is followed by the first trial
  a_r2_dis_to_trial: assert property (@(posedge clk) disable iff (!rst_n)
    ph_dis |=> ph_trial);
  // R3: at most one bit under test
  a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_mask));
  // R3: bits outside the tested one are held through a trial
  a_r3_decided_held: assert property (@(posedge clk) disable iff (!rst_n)
    ph_trial |=> (((z ^ $past(z)) & ~$past(trial_mask)) == '0));
  // R9: last trial leads into a single done cycle
  a_r9_done_after_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_trial && trial_mask[0]) |=> done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a request seen while busy never starts a setup
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !ph_trial) |=> !ph_setup);
  // R7: an unnormalized division is refused
  a_r7_refuse_div: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_div && !y_mag[YW-1]) |=> (err && !ph_setup));
  // R1: result held in the output state while idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(z));
  // R6: sign held while a run is in progress
  a_r6_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(z_neg));
endmodule

bind sar_arith_seq sar_arith_seq_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_div    (req_div),
  .y_mag      (y_mag),
  .ph_setup   (ph_setup),
  .ph_dis     (ph_dis),
  .ph_trial   (ph_trial),
  .trial_mask (trial_mask),
  .z          (z),
  .z_neg      (z_neg),
  .done       (done),
  .err        (err)
);

// File: tb/sim_sar_arith_seq.sv
module sim_sar_arith_seq;
  localparam int XW = 4;
  localparam int YW = 4;
  localparam int ZW = XW + YW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_div = 1'b0;
  logic [XW-1:0] x_mag = '0;
  logic          x_neg = 1'b0;
  logic [YW-1:0] y_mag = '0;
  logic          y_neg = 1'b0;
  logic          cmp_pos;
  logic          ph_setup, ph_dis, ph_trial;
  logic [ZW-1:0] trial_mask;
  logic [XW-1:0] arr_hi;
  logic [YW-1:0] arr_lo;
  logic [XW-1:0] op_x_code;
  logic [YW-1:0] op_y_code;
  logic          op_div;
  logic [ZW-1:0] z;
  logic          z_neg;
  logic          done;
  logic          err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // comparator model state
  int unsigned cur_x = 0, cur_y = 1;
  bit cur_div = 0;
  int force_cmp = 0;  // 0 model, 1 always high, 2 always low

  always #5ns clk = ~clk;

  sar_arith_seq #(.XW(XW), .YW(YW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_div(req_div), .x_mag(x_mag), .x_neg(x_neg), .y_mag(y_mag), .y_neg(y_neg),
    .cmp_pos(cmp_pos), .ph_setup(ph_setup), .ph_dis(ph_dis), .ph_trial(ph_trial),
    .trial_mask(trial_mask), .arr_hi(arr_hi), .arr_lo(arr_lo),
    .op_x_code(op_x_code), .op_y_code(op_y_code), .op_div(op_div),
    .z(z), .z_neg(z_neg), .done(done), .err(err)
  );

  // Behavioural charge-balance comparator: residual positive while trial fits
  always_comb begin
    if (force_cmp == 1) cmp_pos = 1'b1;
    else if (force_cmp == 2) cmp_pos = 1'b0;
    else if (cur_div)
      cmp_pos = (int'({arr_hi, arr_lo}) * int'(cur_y)) <= (int'(cur_x) << (2*YW-1));
    else
      cmp_pos = int'({arr_hi, arr_lo}) <= int'(cur_x * cur_y);
  end

  function automatic int unsigned exp_result(bit dv, int unsigned xm, int unsigned ym);
    if (dv) return (xm * (1 << (2*YW-1))) / ym;
    return xm * ym;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Run one accepted operation; inject = drive other operands while busy
  task automatic run_op(bit dv, int unsigned xm, bit xn, int unsigned ym, bit yn,
                        int fc, bit inject);
    int cycles, n_set, n_dis, n_tr, bitpos;
    int unsigned partial, expz;
    bit seq_ok;
    cur_x = xm; cur_y = ym; cur_div = dv; force_cmp = fc;
    @(negedge clk);
    req_div = dv; x_mag = XW'(xm); x_neg = xn; y_mag = YW'(ym); y_neg = yn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 1; n_set = 0; n_dis = 0; n_tr = 0; bitpos = ZW - 1;
    partial = 0; seq_ok = 1;
    while (!done && cycles < 60) begin
      if (ph_setup) n_set++;
      if (ph_dis) n_dis++;
      if (ph_trial) begin
        n_tr++;
        if (bitpos < 0 || int'({arr_hi, arr_lo}) != int'(partial | (1 << bitpos))
            || int'(trial_mask) != (1 << bitpos)) seq_ok = 0;
        if (cmp_pos && bitpos >= 0) partial = partial | (1 << bitpos);
        bitpos--;
      end
      if (inject && cycles == 3) begin
        req_valid = 1'b1; req_div = 1'b0; x_mag = '1; y_mag = '1;
        x_neg = ~xn; y_neg = yn;
      end
      if (inject && cycles == ZW) req_valid = 1'b0;
      @(negedge clk);
      cycles++;
    end
    // R2: latency and phase counts
    check(cycles == ZW + 3, "R2 latency", cycles, ZW + 3);
    check(n_set == 1 && n_dis == 1 && n_tr == ZW, "R2 phase counts",
          n_set * 100 + n_dis * 10 + n_tr, 110 + ZW);
    // R3: MSB-first trial words with the tested bit forced to 1
    check(seq_ok, "R3 trial sequence", int'(seq_ok), 1);
    if (fc == 1) expz = (1 << ZW) - 1;
    else if (fc == 2) expz = 0;
    else expz = exp_result(dv, xm, ym);
    if (dv) check(int'(z) == int'(expz), "R5 quotient", int'(z), int'(expz));
    else    check(int'(z) == int'(expz), "R4 product", int'(z), int'(expz));
    check(z_neg == (xn ^ yn), "R6 sign", int'(z_neg), int'(xn ^ yn));
    check(!err && req_ready, "R7 err clear / ready", int'(err), 0);
    check(int'({arr_hi, arr_lo}) == int'(z) && int'(op_x_code) == int'(xm)
          && int'(op_y_code) == int'(ym) && op_div == dv, "R10 codes",
          int'({arr_hi, arr_lo}), int'(z));
    if (inject) check(int'(z) == int'(expz), "R8 busy request ignored", int'(z), int'(expz));
    @(negedge clk);
    check(!done && !ph_setup, "R9 done single pulse", int'(done), 0);
    check(int'(z) == int'(expz), "R1 result held", int'(z), int'(expz));
  endtask

  initial begin
    #1ms;
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int unsigned seed, zprev;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready && z == '0 && !err && !done && !ph_setup && !ph_dis && !ph_trial,
          "R1 reset state", int'(z), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && z == '0, "R1 idle after reset", int'(z), 0);

    // Directed cases
    run_op(0, 7, 1, 12, 0, 0, 0);    // R4: 84, negative
    run_op(1, 8, 0, 15, 0, 0, 0);    // R5: 68
    run_op(0, 15, 1, 15, 1, 0, 0);   // R4: 225
    run_op(0, 0, 0, 9, 0, 0, 0);     // R4: zero
    run_op(1, 15, 0, 8, 1, 0, 0);    // R5: max quotient 240
    run_op(1, 0, 1, 8, 0, 0, 0);     // R5: zero dividend
    run_op(0, 5, 0, 3, 0, 1, 0);     // R3: comparator always high
    run_op(0, 5, 0, 3, 0, 2, 0);     // R3: comparator always low
    run_op(0, 9, 0, 11, 1, 0, 1);    // R8: request during run

    // R7: unnormalized divisor refused
    zprev = z;
    @(negedge clk);
    req_div = 1'b1; x_mag = 4'd6; y_mag = 4'd3; x_neg = 1'b1; y_neg = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(err && !ph_setup && req_ready, "R7 refused", int'(err), 1);
    check(int'(z) == int'(zprev) && z_neg == 1'b1 && int'(op_x_code) == 9,
          "R7 state kept", int'(z), int'(zprev));
    repeat (3) @(negedge clk);
    check(!done && !ph_trial, "R7 no run", int'(done), 0);
    run_op(1, 3, 0, 13, 0, 0, 0);    // R7: err cleared by good request

    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit dv;
      int unsigned xm, ym;
      dv = 1'($urandom);
      xm = $urandom % (1 << XW);
      ym = $urandom % (1 << YW);
      if (dv) ym = ym | (1 << (YW-1));
      run_op(dv, xm, 1'($urandom), ym, 1'($urandom), 0, (i % 10) == 3);
    end
    finish_run();
  end
endmodule